// File: doc/BRIEF.md
# Serial Clock Rate Divider

This block derives a serial bit clock from the core clock. The divide ratio comes from a field in a control word, and that field can be read in one of two ways. In the legacy reading the field is narrow and gives only even ratios. In the extended reading the field is wider and gives any ratio up to 4096. When the audio source is selected, the control-word field is overridden and the ratio is set instead by a small prescaler together with a coarse post-divider.

Alongside the divided clock, the block emits two single-cycle strobes, one at the rising edge and one at the falling edge of the bit clock, for use by downstream shift logic. When the divide setting changes, the new value is loaded only at the next period boundary, so the output never produces a shortened pulse. Dropping the enable parks the clock low. Raising it again starts a fresh period on the next cycle.

Top module: `scr_clkdiv`

## Requirements
- R1: During synchronous reset (`rst_n` low) `sclk`, `sclk_rise` and `sclk_fall` are all 0.
- R2: While `en` is low, `sclk`, `sclk_rise` and `sclk_fall` are 0 from the next clock edge on. On the first edge with `en` high, a new period starts: `sclk` and `sclk_rise` are both 1.
- R3: With `wide_mode`=0 and `src_audio`=0, the ratio is F*2+2, where F = `ctrl_word[15:8]`. `ctrl_word[19:16]` is ignored in this mode.
- R4: With `wide_mode`=1 and `src_audio`=0, the ratio is F+1, where F = `ctrl_word[19:8]`. This gives ratios from 1 to 4096.
- R5: For a ratio R, `sclk` is high for ceil(R/2) core cycles and low for floor(R/2) cycles. For R=1, `sclk` stays high and `sclk_rise` pulses every cycle.
- R6: `sclk_rise` is 1 exactly in the first high cycle of each period. `sclk_fall` is 1 exactly in the first low cycle. The two strobes are never 1 together.
- R7: With `src_audio`=1, `ctrl_word` is ignored and the main divider acts as ratio 1. The ratio is then (P+1)*D, where P = `aud_cfg[2:0]` and D is the post-divide factor.
- R8: The post-divide factor D is chosen by priority. D is 1 if `aud_cfg[3]` is set. Otherwise D is 8 if `aud_cfg[4]` is set and `wide_mode`=1. Otherwise D is 4.
- R9: With `wide_mode`=0, `aud_cfg[4]` has no effect.
- R10: A change to any divide input made in the middle of a period leaves that period's high and low lengths unchanged. The new ratio applies from the next `sclk_rise`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low parks the output |
| wide_mode | input | 1 | 0: even-only legacy decode; 1: linear extended decode |
| src_audio | input | 1 | 1 selects the audio prescaler/post-divider path |
| ctrl_word | input | 20 | Control word; divider field starts at bit 8 |
| aud_cfg | input | 8 | Audio divider: [2:0] prescaler, [3] post divide-by-1, [4] post divide-by-8 |
| sclk | output | 1 | Divided bit clock |
| sclk_rise | output | 1 | One-cycle strobe in the first high cycle of a period |
| sclk_fall | output | 1 | One-cycle strobe in the first low cycle of a period |

## Verification
A wrong decode or a wrong post-divide choice changes the high and low run lengths at the ports. This shows up within one full period of the new ratio, at most 4096 core cycles after the boundary where the ratio is loaded. A period counter that skips or overshoots shows up as a missing or extra `sclk_rise` in the first affected period. Loading the ratio at the wrong time shows up as a shortened period right after a mid-period change. A disable path that does not clear state shows up on the first cycle after `en` rises, as a missing `sclk_rise`.

// File: rtl/scr_pkg.sv
// Shared types for the serial clock rate divider.
// Assumes: nothing beyond the enum encoding below being private to the block.
package scr_pkg;
    typedef enum logic [1:0] {
        POST_BY1 = 2'd0,
        POST_BY4 = 2'd1,
        POST_BY8 = 2'd2
    } post_sel_e;
endpackage

// File: rtl/scr_field_decode.sv
// Turns the divider field of the control word into a divide ratio.
// Assumes: RATIO_W can hold both EXT max (2**EXT_W) and legacy max (2**LEG_W*2).
module scr_field_decode #(
    parameter int CTRL_W    = 20,
    parameter int FIELD_LSB = 8,
    parameter int LEG_W     = 8,
    parameter int EXT_W     = 12,
    parameter int RATIO_W   = 13
) (
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic               wide_mode,
    output logic [RATIO_W-1:0] ratio
);
    logic [LEG_W-1:0]   leg_f;
    logic [EXT_W-1:0]   ext_f;
    logic [RATIO_W-1:0] leg_ratio;
    logic [RATIO_W-1:0] ext_ratio;

    assign leg_f = ctrl_word[FIELD_LSB +: LEG_W];
    assign ext_f = ctrl_word[FIELD_LSB +: EXT_W];

    // Compute both candidate ratios and pick by mode.
    always_comb begin
        leg_ratio = (RATIO_W'(leg_f) << 1) + RATIO_W'(2);
        ext_ratio = RATIO_W'(ext_f) + RATIO_W'(1);
        ratio     = wide_mode ? ext_ratio : leg_ratio;
    end
endmodule

// File: rtl/scr_audio_ratio.sv
// Audio path ratio: (prescaler + 1) times a post-divide of 1, 4 or 8.
// Assumes: divide-by-8 only exists in the extended variant (wide_mode=1).
module scr_audio_ratio
    import scr_pkg::*;
#(
    parameter int AUD_W   = 8,
    parameter int PRE_W   = 3,
    parameter int BY1_BIT = 3,
    parameter int BY8_BIT = 4,
    parameter int RATIO_W = 13
) (
    input  logic [AUD_W-1:0]   aud_cfg,
    input  logic               wide_mode,
    output logic [RATIO_W-1:0] ratio
);
    post_sel_e          post;
    logic [RATIO_W-1:0] base;

    // Pick the post-divider with divide-by-1 taking priority.
    always_comb begin
        if (aud_cfg[BY1_BIT])                    post = POST_BY1;
        else if (aud_cfg[BY8_BIT] && wide_mode)  post = POST_BY8;
        else                                     post = POST_BY4;
    end

    // Scale the prescaled count by the chosen post-divide.
    always_comb begin
        base = RATIO_W'(aud_cfg[PRE_W-1:0]) + RATIO_W'(1);
        case (post)
            POST_BY1: ratio = base;
            POST_BY8: ratio = base << 3;
            default:  ratio = base << 2;
        endcase
    end
endmodule

// File: rtl/scr_period_gen.sv
// Counts core cycles per output period and shapes sclk plus edge strobes.
// Assumes: ratio_in is never zero; it is sampled only at period boundaries.
module scr_period_gen #(
    parameter int RATIO_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               sclk,
    output logic               sclk_rise,
    output logic               sclk_fall
);
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [RATIO_W-1:0] hi_d;
    logic               run_q;
    logic               wrap;

    // Decide the next count and whether a new ratio is loaded.
    always_comb begin
        wrap = !run_q || (cnt_q == ratio_q - RATIO_W'(1));
        if (wrap) begin
            cnt_d   = '0;
            ratio_d = ratio_in;
        end else begin
            cnt_d   = cnt_q + RATIO_W'(1);
            ratio_d = ratio_q;
        end
        hi_d = (ratio_d + RATIO_W'(1)) >> 1;
    end

    // Register count, active ratio and the shaped outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ratio_q   <= RATIO_W'(1);
            run_q     <= 1'b0;
            sclk      <= 1'b0;
            sclk_rise <= 1'b0;
            sclk_fall <= 1'b0;
        end else if (!en) begin
            cnt_q     <= '0;
            ratio_q   <= RATIO_W'(1);
            run_q     <= 1'b0;
            sclk      <= 1'b0;
            sclk_rise <= 1'b0;
            sclk_fall <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            ratio_q   <= ratio_d;
            run_q     <= 1'b1;
            sclk      <= (cnt_d < hi_d);
            sclk_rise <= (cnt_d == '0);
            sclk_fall <= (cnt_d == hi_d);
        end
    end

    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < ratio_q)); // R5
    AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk && !sclk_rise && !sclk_fall && cnt_q == '0)); // R2
    AST_NO_MIDPERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && cnt_q != ratio_q - RATIO_W'(1)) |=> $stable(ratio_q)); // R10
    AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall)); // R6
    AST_RISE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> sclk); // R6
    AST_FALL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |-> !sclk); // R6
endmodule

// File: rtl/scr_clkdiv.sv
// Serial clock rate divider top: selects main or audio ratio, feeds the
// period generator. Assumes ctrl_word/aud_cfg are quasi-static register values.
module scr_clkdiv #(
    parameter int CTRL_W    = 20,
    parameter int FIELD_LSB = 8,
    parameter int LEG_W     = 8,
    parameter int EXT_W     = 12,
    parameter int AUD_W     = 8,
    parameter int PRE_W     = 3,
    parameter int BY1_BIT   = 3,
    parameter int BY8_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wide_mode,
    input  logic              src_audio,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [AUD_W-1:0]  aud_cfg,
    output logic              sclk,
    output logic              sclk_rise,
    output logic              sclk_fall
);
    localparam int BIG_W   = (EXT_W > LEG_W + 1) ? EXT_W : LEG_W + 1;
    localparam int RATIO_W = BIG_W + 1;

    logic [RATIO_W-1:0] main_ratio;
    logic [RATIO_W-1:0] aud_ratio;
    logic [RATIO_W-1:0] ratio_sel;

    scr_field_decode #(
        .CTRL_W(CTRL_W), .FIELD_LSB(FIELD_LSB), .LEG_W(LEG_W),
        .EXT_W(EXT_W), .RATIO_W(RATIO_W)
    ) u_field (
        .ctrl_word(ctrl_word),
        .wide_mode(wide_mode),
        .ratio(main_ratio)
    );

    scr_audio_ratio #(
        .AUD_W(AUD_W), .PRE_W(PRE_W), .BY1_BIT(BY1_BIT),
        .BY8_BIT(BY8_BIT), .RATIO_W(RATIO_W)
    ) u_audio (
        .aud_cfg(aud_cfg),
        .wide_mode(wide_mode),
        .ratio(aud_ratio)
    );

    // Audio source forces the main stage to 1, leaving the audio ratio alone.
    always_comb begin
        ratio_sel = src_audio ? aud_ratio : main_ratio;
    end

    scr_period_gen #(.RATIO_W(RATIO_W)) u_period (
        .clk(clk),
        .rst_n(rst_n),
        .en(en),
        .ratio_in(ratio_sel),
        .sclk(sclk),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall)
    );

    AST_LEGACY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_audio && !wide_mode) |-> (ratio_sel[0] == 1'b0)); // R3
    AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_sel != '0); // R4
    AST_AUDIO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        src_audio |-> (ratio_sel <= RATIO_W'(64))); // R7
endmodule

// File: tb/scr_clkdiv_bench.sv
`timescale 1ns/1ps
module scr_clkdiv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        wide_mode = 1'b0;
    logic        src_audio = 1'b0;
    logic [19:0] ctrl_word = 20'h00300;
    logic [7:0]  aud_cfg = 8'h00;
    logic        sclk, sclk_rise, sclk_fall;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    scr_clkdiv u_scr_clkdiv (
        .clk(clk), .rst_n(rst_n), .en(en), .wide_mode(wide_mode),
        .src_audio(src_audio), .ctrl_word(ctrl_word), .aud_cfg(aud_cfg),
        .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        wide;
        logic        aud;
        logic [19:0] ctrl;
        logic [7:0]  acfg;
        logic [15:0] hi;
        logic [15:0] lo;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{"R3", 1'b0, 1'b0, 20'h00000, 8'h00, 16'd1,    16'd1},
        '{"R3", 1'b0, 1'b0, 20'h00300, 8'h00, 16'd4,    16'd4},
        '{"R3", 1'b0, 1'b0, 20'hFFF00, 8'h00, 16'd256,  16'd256},
        '{"R5", 1'b1, 1'b0, 20'h00400, 8'h00, 16'd3,    16'd2},
        '{"R4", 1'b1, 1'b0, 20'hFFF00, 8'h00, 16'd2048, 16'd2048},
        '{"R4", 1'b1, 1'b0, 20'h0FF00, 8'h00, 16'd128,  16'd128},
        '{"R7", 1'b0, 1'b1, 20'h12345, 8'h0A, 16'd2,    16'd1},
        '{"R8", 1'b1, 1'b1, 20'h00000, 8'h01, 16'd4,    16'd4},
        '{"R8", 1'b1, 1'b1, 20'hABC00, 8'h14, 16'd20,   16'd20},
        '{"R9", 1'b0, 1'b1, 20'h00000, 8'h14, 16'd10,   16'd10},
        '{"R8", 1'b1, 1'b1, 20'h00000, 8'h1E, 16'd4,    16'd3}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        while (!sclk_rise) @(negedge clk);
    endtask

    // Starts at a negedge where sclk_rise=1; ends at the next such negedge.
    task automatic measure(output int hi, output int lo, output int fall_seen);
        hi = 0; lo = 0; fall_seen = 0;
        while (sclk) begin hi++; @(negedge clk); end
        fall_seen = int'(sclk_fall);
        while (!sclk_rise) begin lo++; @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hi, lo, fs;
        // R1: outputs quiet under reset
        repeat (3) @(negedge clk);
        check("R1", "sclk in reset", int'(sclk), 0);
        check("R1", "rise in reset", int'(sclk_rise), 0);
        check("R1", "fall in reset", int'(sclk_fall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "first period sclk", int'(sclk), 1);
        check("R2", "first period rise", int'(sclk_rise), 1);

        // R2: disable parks output low, re-enable restarts a period
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2", "sclk while off", int'(sclk), 0);
            check("R2", "strobes while off", int'(sclk_rise | sclk_fall), 0);
        end
        en = 1'b1;
        @(negedge clk);
        check("R2", "rise on enable", int'(sclk_rise), 1);
        measure(hi, lo, fs);
        check("R2", "high after enable", hi, 4);
        check("R2", "low after enable", lo, 4);

        // Table walk: decode modes, duty, audio path
        for (int v = 0; v < NV; v++) begin
            string t;
            t = $sformatf("%s", VEC[v].tag);
            wide_mode = VEC[v].wide;
            src_audio = VEC[v].aud;
            ctrl_word = VEC[v].ctrl;
            aud_cfg   = VEC[v].acfg;
            @(negedge clk);
            wait_rise();
            measure(hi, lo, fs);
            check(t, $sformatf("vec%0d high", v), hi, int'(VEC[v].hi));
            check(t, $sformatf("vec%0d low", v), lo, int'(VEC[v].lo));
            check("R6", $sformatf("vec%0d fall strobe", v), fs, 1);
        end

        // R10: mid-period change waits for the boundary
        wide_mode = 1'b0; src_audio = 1'b0; ctrl_word = 20'h00300;
        @(negedge clk);
        wait_rise();
        measure(hi, lo, fs);
        ctrl_word = 20'h00000;
        measure(hi, lo, fs);
        check("R10", "old period high kept", hi, 4);
        check("R10", "old period low kept", lo, 4);
        measure(hi, lo, fs);
        check("R10", "new period high", hi, 1);
        check("R10", "new period low", lo, 1);

        // R5: ratio 1 holds sclk high, rise every cycle
        wide_mode = 1'b1; ctrl_word = 20'h00000;
        @(negedge clk);
        wait_rise();
        @(negedge clk);
        wait_rise();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R5", "ratio1 sclk", int'(sclk), 1);
            check("R5", "ratio1 rise", int'(sclk_rise), 1);
            check("R6", "ratio1 no fall", int'(sclk_fall), 0);
        end
        finish_run();
    end
endmodule